// File: doc/BRIEF.md
# Serial Register Access Port

This block is a byte-oriented serial slave that lets a host processor read and write a bank of eight 8-bit control registers over four wires. The wires are a serial clock, an active-low select, a data input and a data output. The serial lines are treated as slow, asynchronous inputs. They are brought into the local clock domain by synchronizer chains, and their edges are detected there, so all internal logic runs on a single fast clock.

A transaction opens when select goes low. The first complete byte is always a command. Its bit 0 chooses the direction (1 = read, 0 = write), bits 3..1 carry the register index, and bits 7..4 are ignored. Every later byte in the same select window is data for that index.

- **Write:** each completed data byte raises a one-cycle write strobe toward the register bank.
- **Read:** the addressed register is loaded into a transmit shifter and clocked out, and it is reloaded after every completed byte.

A static strap input sets the bit order for both directions. When select goes high, the transaction ends and any partial byte is dropped.

Top module: `ser_ctl_port`

## Requirements
- R1: While reset is asserted and before any transaction, `sdo_oe_o` = 0, `reg_we_o` = 0 and `sdo_o` = 0.
- R2: `sdo_oe_o` is 1 while `cs_n_i` is low and 0 while it is high, after a short synchronizer latency.
- R3: The first byte after `cs_n_i` falls is a command: bit 0 = 1 selects read, 0 selects write; bits 3..1 give the register index; bits 7..4 have no effect.
- R4: In a write transaction, each completed data byte produces exactly one single-cycle `reg_we_o` pulse carrying the command's index on `reg_addr_o` and the byte on `reg_wdata_o`. Repeated bytes go to the same index, so the last one wins.
- R5: In a read transaction, the addressed register value appears on `sdo_o` starting at the first falling serial-clock edge after the command byte. The same register is reloaded for every further data byte.
- R6: With `msb_first_i` = 0, bytes travel bit 0 first in both directions. With `msb_first_i` = 1, they travel bit 7 first.
- R7: `sdi_i` is sampled on rising serial-clock edges. `sdo_o` changes only after a falling serial-clock edge, or when it clears while select is high.
- R8: Raising `cs_n_i` in the middle of a byte discards that byte (no write) and resets the bit count, so the next transaction starts with a fresh command byte.
- R9: A byte after the first one in the same select window is never taken as a command, even if its bit pattern looks like one. A new command needs `cs_n_i` to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; must be at least 8x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low transaction select |
| sdi_i | input | 1 | Serial data from the host |
| msb_first_i | input | 1 | Bit-order strap: 0 = bit 0 first, 1 = bit 7 first |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (0 = line released) |
| reg_we_o | output | 1 | Register write strobe, one cycle per data byte |
| reg_addr_o | output | 3 | Register index for reads and writes |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Read data from the register bank at `reg_addr_o` |

## Verification
The hardest situation to reach from the ports is select rising partway through a byte that follows an already completed data byte. The completed byte must be written, the partial one must be lost, and the next select window must still begin with a command.

The stimulus reaches this case in two steps:
- A bit-level transfer task stops after a chosen number of serial clock periods, both during a data byte and during a command byte.
- After each abort, a read or a fresh write checks that only the expected register changed.

A second hard case is a data byte whose pattern is a valid read command. It is sent as the second byte of a write, and the bench then reads both the intended index and the index that pattern names.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/ser_ctl_sync.sv
// Per-bit synchronizer chains with edge detection on the synchronized level.
module ser_ctl_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    logic [CHAIN-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN-2:0], d_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {CHAIN{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign q_o[g]    = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/ser_ctl_shift.sv
// Receive shifter with bit counter, and transmit shifter with serial output.
module ser_ctl_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sdi_i,
  input  logic         msb_first_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o,
  output logic         sdo_o
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rx_q, rx_d;
  logic             done_q, done_d;
  logic [W-1:0]     tx_q, tx_d;
  logic             sdo_q, sdo_d;

  // receive side
  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (rise_i) begin
      rx_d = msb_first_i ? {rx_q[W-2:0], sdi_i} : {sdi_i, rx_q[W-1:1]};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // transmit side
  always_comb begin
    tx_d  = tx_q;
    sdo_d = sdo_q;
    if (clr_i) begin
      tx_d  = '0;
      sdo_d = 1'b0;
    end else if (load_i) begin
      tx_d = load_data_i;
    end else if (fall_i) begin
      sdo_d = msb_first_i ? tx_q[W-1] : tx_q[0];
      tx_d  = msb_first_i ? {tx_q[W-2:0], 1'b0} : {1'b0, tx_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      done_q <= done_d;
      tx_q   <= tx_d;
      sdo_q  <= sdo_d;
    end
  end

  assign byte_done_o = done_q;
  assign byte_o      = rx_q;
  assign sdo_o       = sdo_q;
endmodule

// File: rtl/ser_ctl_seq.sv
// Command/data sequencing: decodes the command byte, issues writes and read loads.
module ser_ctl_seq
  import ser_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              byte_done_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              load_o,
  output logic              oe_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int RW_BIT = 0;
  localparam int A_LSB  = 1;
  localparam int A_MSB  = ADDR_W;

  phase_e            phase_q, phase_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              load_q, load_d;
  logic              oe_q, oe_d;

  always_comb begin
    phase_d = phase_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    load_d  = 1'b0;
    oe_d    = cs_act_i;
    if (!cs_act_i) begin
      phase_d = PH_CMD;
    end else if (byte_done_i) begin
      if (phase_q == PH_CMD) begin
        addr_d  = byte_i[A_MSB:A_LSB];
        rd_d    = byte_i[RW_BIT];
        load_d  = byte_i[RW_BIT];
        phase_d = PH_DATA;
      end else if (rd_q) begin
        load_d = 1'b1;
      end else begin
        we_d    = 1'b1;
        wdata_d = byte_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      load_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      load_q  <= load_d;
      oe_q    <= oe_d;
    end
  end

  assign load_o  = load_q;
  assign oe_o    = oe_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic              msb_first_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int NSIG = 3;   // {sdi, cs_n, sclk}
  localparam logic [NSIG-1:0] SYNC_RST = 3'b010;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NSIG-1:0] lvl, rise, fall;
  ser_ctl_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .d_i    ({sdi_i, cs_n_i, sclk_i}),
    .q_o    (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic sclk_rise, sclk_fall, cs_act, sdi_s;
  assign sclk_rise = rise[0];
  assign sclk_fall = fall[0];
  assign cs_act    = ~lvl[1];
  assign sdi_s     = lvl[2];

  logic              byte_done, load;
  logic [DATA_W-1:0] byte_val;

  ser_ctl_shift #(.W(DATA_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (~cs_act),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .sdi_i       (sdi_s),
    .msb_first_i (msb_first_i),
    .load_i      (load),
    .load_data_i (reg_rdata_i),
    .byte_done_o (byte_done),
    .byte_o      (byte_val),
    .sdo_o       (sdo_o)
  );

  ser_ctl_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_act_i    (cs_act),
    .byte_done_i (byte_done),
    .byte_i      (byte_val),
    .load_o      (load),
    .oe_o        (sdo_oe_o),
    .we_o        (reg_we_o),
    .addr_o      (reg_addr_o),
    .wdata_o     (reg_wdata_o)
  );
endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_fall,
  input logic              cs_act,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  // R7: serial output moves only after a falling serial-clock edge or an idle clear
  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> ($past(sclk_fall) || !$past(cs_act)));

  // R4: a write strobe never lasts more than one cycle
  a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R4: the index does not move across a write strobe
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> $stable(reg_addr_o));

  // R2: the output is released one cycle after select is seen high
  a_r2_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe_o);

  // R8: writes happen only inside an active select window
  a_r8_we_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> sdo_oe_o);

  // R1: no strobe and no drive while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!reg_we_o && !sdo_oe_o));
endmodule

bind ser_ctl_port ser_ctl_port_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sclk_fall  (sclk_fall),
  .cs_act     (cs_act),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/test_ser_ctl_port.sv
module test_ser_ctl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;   // local clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, msb = 1'b0;
  logic       sdo, sdo_oe, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0]  bank   [8];   // register bank attached to the design
  logic [7:0]  shadow [8];   // expected contents
  logic [10:0] exp_q [$];    // expected {addr, data} writes
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign reg_rdata = bank[reg_addr];

  ser_ctl_port i_ser_ctl_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .msb_first_i(msb), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_we_o(reg_we),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected writes (R4)
  always @(negedge clk) begin
    if (rst_n && reg_we === 1'b1) begin
      if (exp_q.size() == 0) check("R4 unexpected write", {21'd0, reg_addr, reg_wdata}, 32'hFFFF_FFFF);
      else check("R4 write addr/data", {21'd0, reg_addr, reg_wdata}, {21'd0, exp_q.pop_front()});
      bank[reg_addr] = reg_wdata;
    end
  end

  task automatic xfer_bits(input logic [7:0] b, input int nbits, input bit chk,
                           input logic [7:0] exp, input string req);
    logic [7:0] got = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx = msb ? 7 - i : i;
      sdi = b[idx];
      wait_clk(HALF);
      got[idx] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    if (chk) check(req, {24'd0, got}, {24'd0, exp});
  endtask

  task automatic cs_begin();
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    check("R2 oe while selected", {31'd0, sdo_oe}, 32'd1);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
    check("R2 oe released", {31'd0, sdo_oe}, 32'd0);
  endtask

  task automatic wr_txn(input logic [2:0] a, input logic [3:0] junk,
                        input logic [7:0] d0, input logic [7:0] d1, input int n);
    cs_begin();
    xfer_bits({junk, a, 1'b0}, 8, 0, 8'h00, "");
    exp_q.push_back({a, d0}); shadow[a] = d0;
    xfer_bits(d0, 8, 0, 8'h00, "");
    if (n > 1) begin
      exp_q.push_back({a, d1}); shadow[a] = d1;
      xfer_bits(d1, 8, 0, 8'h00, "");
    end
    cs_end();
  endtask

  task automatic rd_txn(input logic [2:0] a, input int n, input string req);
    cs_begin();
    xfer_bits({4'h0, a, 1'b1}, 8, 0, 8'h00, "");
    for (int k = 0; k < n; k++) xfer_bits(8'hA5, 8, 1, shadow[a], req);
    cs_end();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      bank[i]   = 8'h10 + 8'(i);
      shadow[i] = 8'h10 + 8'(i);
    end
    wait_clk(5);
    check("R1 oe in reset", {31'd0, sdo_oe}, 32'd0);
    check("R1 we in reset", {31'd0, reg_we}, 32'd0);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 sdo after reset", {31'd0, sdo}, 32'd0);
    check("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);

    // LSB-first mode (R6 msb_first_i = 0)
    wr_txn(3'd3, 4'h0, 8'h5A, 8'h00, 1);              // R4
    rd_txn(3'd3, 1, "R5 R6 lsb read");
    wr_txn(3'd2, 4'hF, 8'hC3, 8'h81, 2);              // R3 junk upper bits, R4 overwrite
    rd_txn(3'd2, 2, "R5 reread same index");
    rd_txn(3'd6, 1, "R5 untouched register");

    // R9: second byte looks like a read command for index 5
    wr_txn(3'd1, 4'h0, 8'h0B, 8'h77, 2);
    rd_txn(3'd5, 1, "R9 index 5 untouched");
    rd_txn(3'd1, 1, "R9 data byte kept as data");

    // R8: abort in the middle of a data byte
    cs_begin();
    xfer_bits({4'h0, 3'd6, 1'b0}, 8, 0, 8'h00, "");
    exp_q.push_back({3'd6, 8'h3C}); shadow[6] = 8'h3C;
    xfer_bits(8'h3C, 8, 0, 8'h00, "");
    xfer_bits(8'hFF, 4, 0, 8'h00, "");
    cs_end();
    rd_txn(3'd6, 1, "R8 partial byte dropped");

    // R8: abort in the middle of a command byte, then a clean transaction
    cs_begin();
    xfer_bits(8'hFF, 5, 0, 8'h00, "");
    cs_end();
    wr_txn(3'd4, 4'h0, 8'h99, 8'h00, 1);
    rd_txn(3'd4, 1, "R8 count reset after abort");

    // MSB-first mode (R6 msb_first_i = 1)
    msb = 1'b1;
    wr_txn(3'd7, 4'h6, 8'hE1, 8'h00, 1);
    rd_txn(3'd7, 1, "R6 msb read after msb write");
    rd_txn(3'd0, 1, "R6 msb read of initial value");
    rd_txn(3'd2, 1, "R6 msb read of lsb-written value");

    wait_clk(4);
    check("R4 all expected writes seen", exp_q.size(), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule